// File: doc/BRIEF.md
# Burst-Addressed Synchronous SRAM Port

This block is a single clocked port onto an on-chip static RAM of 18-bit words, with a built-in burst address counter. On every rising clock edge the port works out one effective address. It has four ways to get it: force the address to zero, capture the external address, step the stored counter by one, or reuse the stored counter. The chosen address becomes the new counter value. The port then writes to that location or reads from it, all in the same cycle. There is no idle cycle when the counter is zeroed or loaded.

Writes can update the lower and upper halves of a word independently. Reads are pipelined: the word appears on the registered output one clock after its address is presented. A valid flag marks it, and this flag replaces an output-enabled bus. The depth is set by `ADDR_W`. A 64K-word array uses `ADDR_W = 16`. The default is a 1K-word array, which keeps elaboration light.

Top module: `sram_burst_port`

## Requirements
- R1: While `load_n` is low (and `crst_n` high), the location accessed at a rising edge is `addr_i`, and that address is stored in the counter. Successive loads may jump to any address.
- R2: With `crst_n` and `load_n` high and `inc_n` low, the counter steps from A to A+1 and location A+1 is accessed in that same cycle.
- R3: With `crst_n`, `load_n` and `inc_n` all high, the counter keeps its value and the same location is accessed again.
- R4: With `crst_n` low, the counter becomes 0 and location 0 is accessed in that same cycle, together with any read or write.
- R5: Control priority is `crst_n` first, then `load_n`, then `inc_n`, then hold.
- R6: Incrementing from the top address (2^ADDR_W−1) wraps the counter to 0.
- R7: A write takes place only when `ce0_n` is low, `ce1` is high and `rw_n` is low (`rw_n` high means read). In any other cycle the array is left unchanged.
- R8: Byte enables are active low. `lb_n` guards bits [8:0] and `ub_n` guards bits [17:9]. A write with both enables high changes nothing.
- R9: A selected read at edge N presents the addressed word on `rdata_o`, with `rvalid_o` high, from edge N until edge N+1.
- R10: After an edge with a write or with the port deselected, `rvalid_o` is low and `rdata_o` keeps its previous value.
- R11: After reset, `rdata_o` is 0, `rvalid_o` is 0 and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | ADDR_W | External address |
| load_n | input | 1 | Active-low: take external address |
| inc_n | input | 1 | Active-low: advance counter |
| crst_n | input | 1 | Active-low: zero the counter |
| rw_n | input | 1 | 1 = read, 0 = write |
| ce0_n | input | 1 | Active-low chip enable |
| ce1 | input | 1 | Active-high chip enable |
| lb_n | input | 1 | Active-low enable for bits [8:0] |
| ub_n | input | 1 | Active-low enable for bits [17:9] |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The counter properties assume that every control input has a known, settled value at each rising edge once reset has been released. They also assume that the synchronised reset has been deasserted for at least one cycle before any `$past` comparison. The stimulus follows these assumptions: the bench changes inputs only on falling edges, holds every control at a defined level throughout reset, and waits several cycles after reset before the first access. A reference model in the bench predicts each read word. Reads target only locations the sequence has written, so no check depends on uninitialised array contents.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  // Source of the effective address for one access cycle.
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_ZERO = 2'd3
  } addr_src_e;

  // Decoded access for one cycle.
  typedef struct packed {
    logic rd;
    logic wr;
  } access_t;

endpackage

// File: rtl/sbp_rst_sync.sv
module sbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sbp_addr_ctr.sv
module sbp_addr_ctr
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_n,
  input  logic              inc_n,
  input  logic              crst_n,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] ctr_q
);

  addr_src_e         src;
  logic [ADDR_W-1:0] ctr_d;

  // Priority: zero, then load, then increment, then hold.
  always_comb begin
    if (!crst_n)      src = SRC_ZERO;
    else if (!load_n) src = SRC_LOAD;
    else if (!inc_n)  src = SRC_INC;
    else              src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_ZERO: ctr_d = '0;
      SRC_LOAD: ctr_d = addr_i;
      SRC_INC:  ctr_d = ctr_q + ADDR_W'(1);
      default:  ctr_d = ctr_q;
    endcase
  end

  // The new counter value is the address used in this very cycle.
  assign eff_addr = ctr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= '0;
    else        ctr_q <= ctr_d;
  end

endmodule

// File: rtl/sbp_mem_array.sv
module sbp_mem_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        lane_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [LANES-1:0][LANE_W-1:0] rd_lanes;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] store [DEPTH];
    logic [LANE_W-1:0] rd_q;
    logic              lane_we;

    assign lane_we = wr_en & lane_en[g];

    always_ff @(posedge clk) begin
      if (lane_we) store[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_q <= '0;
      else if (rd_en) rd_q <= store[addr];
    end

    assign rd_lanes[g] = rd_q;
  end

  assign rdata = rd_lanes;

endmodule

// File: rtl/sbp_access_ctl.sv
module sbp_access_ctl
  import sbp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce0_n,
  input  logic    ce1,
  input  logic    rw_n,
  input  logic    lb_n,
  input  logic    ub_n,
  output access_t acc,
  output logic [1:0] lane_en,
  output logic    rvalid_q
);

  logic sel;
  logic rvalid_d;

  assign sel     = ~ce0_n & ce1;
  assign acc.rd  = sel &  rw_n;
  assign acc.wr  = sel & ~rw_n;
  assign lane_en = {~ub_n, ~lb_n};

  always_comb rvalid_d = acc.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= rvalid_d;
  end

endmodule

// File: rtl/sram_burst_port.sv
module sram_burst_port
  import sbp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              load_n,
  input  logic              inc_n,
  input  logic              crst_n,
  input  logic              rw_n,
  input  logic              ce0_n,
  input  logic              ce1,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  logic              rst_n_s;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] ctr_q;
  access_t           acc;
  logic [1:0]        lane_en;

  sbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sbp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr_i   (addr_i),
    .load_n   (load_n),
    .inc_n    (inc_n),
    .crst_n   (crst_n),
    .eff_addr (eff_addr),
    .ctr_q    (ctr_q)
  );

  sbp_access_ctl u_acc (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ce0_n    (ce0_n),
    .ce1      (ce1),
    .rw_n     (rw_n),
    .lb_n     (lb_n),
    .ub_n     (ub_n),
    .acc      (acc),
    .lane_en  (lane_en),
    .rvalid_q (rvalid_o)
  );

  sbp_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .addr    (eff_addr),
    .wr_en   (acc.wr),
    .rd_en   (acc.rd),
    .lane_en (lane_en),
    .wdata   (wdata_i),
    .rdata   (rdata_o)
  );

endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_i,
  input logic              load_n,
  input logic              inc_n,
  input logic              crst_n,
  input logic              rw_n,
  input logic              ce0_n,
  input logic              ce1,
  input logic [ADDR_W-1:0] ctr_q,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o
);

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (crst_n && !load_n) |=> (ctr_q == $past(addr_i)));

  assert_inc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (crst_n && load_n && !inc_n) |=> (ctr_q == $past(ctr_q) + ADDR_W'(1)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (crst_n && load_n && inc_n) |=> $stable(ctr_q));

  assert_zero_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !crst_n |=> (ctr_q == '0));

  assert_read_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce0_n && ce1 && rw_n) |=> rvalid_o);

  assert_no_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce0_n && ce1 && rw_n) |=> !rvalid_o);

  assert_data_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ce0_n && ce1 && rw_n) |=> $stable(rdata_o));

endmodule

bind sram_burst_port sbp_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .addr_i   (addr_i),
  .load_n   (load_n),
  .inc_n    (inc_n),
  .crst_n   (crst_n),
  .rw_n     (rw_n),
  .ce0_n    (ce0_n),
  .ce1      (ce1),
  .ctr_q    (ctr_q),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o)
);

// File: tb/sram_burst_port_tb_top.sv
module sram_burst_port_tb_top;

  localparam int AW = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          load_n, inc_n, crst_n, rw_n, ce0_n, ce1, lb_n, ub_n;
  logic [DW-1:0] wdata_i;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_en   = 0;

  always #5 clk = ~clk;

  sram_burst_port #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .load_n(load_n),
    .inc_n(inc_n), .crst_n(crst_n), .rw_n(rw_n), .ce0_n(ce0_n), .ce1(ce1),
    .lb_n(lb_n), .ub_n(ub_n), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o)
  );

  // Reference model and scoreboard queues.
  logic [DW-1:0] mdl_mem [1 << AW];
  logic [AW-1:0] mdl_ctr;
  logic [DW-1:0] mdl_rd;
  logic [DW-1:0] q_data  [$];
  logic          q_valid [$];
  string         q_tag   [$];

  task automatic drive(input bit crst, input bit ld, input bit inc,
                       input bit rw, input bit c0, input bit c1,
                       input bit lb, input bit ub,
                       input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input string tag);
    logic [AW-1:0] eff;
    bit            sel;
    @(negedge clk);
    crst_n = crst; load_n = ld; inc_n = inc; rw_n = rw;
    ce0_n = c0; ce1 = c1; lb_n = lb; ub_n = ub; addr_i = a; wdata_i = d;
    if (!crst)     eff = '0;
    else if (!ld)  eff = a;
    else if (!inc) eff = mdl_ctr + 1'b1;
    else           eff = mdl_ctr;
    mdl_ctr = eff;
    sel = !c0 && c1;
    if (sel && !rw) begin
      if (!lb) mdl_mem[eff][8:0]  = d[8:0];
      if (!ub) mdl_mem[eff][17:9] = d[17:9];
    end
    if (sel && rw) mdl_rd = mdl_mem[eff];
    q_data.push_back(mdl_rd);
    q_valid.push_back(sel && rw);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares each edge's result shortly after the edge.
  always @(posedge clk) begin
    #2;
    if (mon_en && q_data.size() > 0) begin
      logic [DW-1:0] ed;
      logic          ev;
      string         tg;
      ed = q_data.pop_front();
      ev = q_valid.pop_front();
      tg = q_tag.pop_front();
      n_checks++;
      if (rvalid_o !== ev || rdata_o !== ed) begin
        n_fail++;
        $display("FAIL %s: rvalid/rdata actual %0b/%h expected %0b/%h",
                 tg, rvalid_o, rdata_o, ev, ed);
      end
    end
  end

  initial begin
    #1_000_000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    addr_i = '0; wdata_i = '0;
    load_n = 1; inc_n = 1; crst_n = 1; rw_n = 1;
    ce0_n = 1; ce1 = 0; lb_n = 1; ub_n = 1;
    mdl_ctr = '0; mdl_rd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state of the outputs
    n_checks++;
    if (rdata_o !== '0 || rvalid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: rvalid/rdata actual %0b/%h expected 0/00000",
               rvalid_o, rdata_o);
    end
    mon_en = 1;

    // R11 / R3: counter starts at 0, hold writes there; load reads it back.
    drive(1,1,1, 0, 0,1, 0,0, 10'h000, 18'h2A5A5, "R11");
    drive(1,0,1, 1, 0,1, 0,0, 10'h000, 18'h00000, "R11");

    // R1 / R2 / R3 / R9: load, burst writes, overwrite on hold, burst read.
    drive(1,0,1, 0, 0,1, 0,0, 10'h005, 18'h11111, "R1");
    drive(1,1,0, 0, 0,1, 0,0, 10'h3C0, 18'h22222, "R2");
    drive(1,1,0, 0, 0,1, 0,0, 10'h3C0, 18'h33333, "R2");
    drive(1,1,1, 0, 0,1, 0,0, 10'h3C0, 18'h04444, "R3");
    drive(1,0,1, 1, 0,1, 0,0, 10'h005, 18'h0, "R1");
    drive(1,1,0, 1, 0,1, 0,0, 10'h000, 18'h0, "R2");
    drive(1,1,0, 1, 0,1, 0,0, 10'h000, 18'h0, "R9");
    drive(1,1,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R3");
    drive(1,0,1, 1, 0,1, 0,0, 10'h006, 18'h0, "R9");

    // R4 / R5: zeroing beats load and increment, access happens in that cycle.
    drive(0,0,0, 0, 0,1, 0,0, 10'h009, 18'h15A5A, "R4");
    drive(1,0,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R4");
    drive(1,0,1, 0, 0,1, 0,0, 10'h009, 18'h0ABCD, "R5");
    drive(1,0,0, 1, 0,1, 0,0, 10'h009, 18'h0, "R5");
    drive(0,1,0, 1, 0,1, 0,0, 10'h009, 18'h0, "R5");

    // R6: increment from the top address wraps to 0.
    drive(1,0,1, 0, 0,1, 0,0, 10'h3FF, 18'h3F00F, "R6");
    drive(1,1,0, 0, 0,1, 0,0, 10'h000, 18'h0F0F0, "R6");
    drive(1,0,1, 1, 0,1, 0,0, 10'h3FF, 18'h0, "R6");
    drive(1,0,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R6");

    // R7 / R10: writes while deselected leave the array and output alone.
    drive(1,0,1, 0, 0,1, 0,0, 10'h014, 18'h12345, "R7");
    drive(1,0,1, 0, 1,1, 0,0, 10'h014, 18'h3FFFF, "R10");
    drive(1,0,1, 0, 0,0, 0,0, 10'h014, 18'h3FFFF, "R10");
    drive(1,0,1, 1, 1,1, 0,0, 10'h014, 18'h0, "R10");
    drive(1,0,1, 1, 0,1, 0,0, 10'h014, 18'h0, "R7");
    drive(1,0,1, 0, 0,1, 0,0, 10'h015, 18'h2B2B2, "R10");

    // R8: byte lanes.
    drive(1,0,1, 0, 0,1, 0,0, 10'h01E, 18'h00000, "R8");
    drive(1,1,1, 0, 0,1, 0,1, 10'h000, 18'h3FFFF, "R8");
    drive(1,1,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R8");
    drive(1,1,1, 0, 0,1, 1,0, 10'h000, 18'h2AAAA, "R8");
    drive(1,1,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R8");
    drive(1,1,1, 0, 0,1, 1,1, 10'h000, 18'h15555, "R8");
    drive(1,1,1, 1, 0,1, 0,0, 10'h000, 18'h0, "R8");

    // Drain: one idle deselected cycle, then wait for the queue to empty.
    drive(1,1,1, 1, 1,0, 1,1, 10'h000, 18'h0, "R10");
    repeat (3) @(negedge clk);
    n_checks++;
    if (q_data.size() != 0) begin
      n_fail++;
      $display("FAIL R9: pending results actual %0d expected 0", q_data.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule